// File: doc/BRIEF.md
# Read Bus Cycle Sequencer with Area-Switch Idle Gaps

This block runs external read cycles for eight chip-select areas on a shared data bus. Each request carries an area number. The block answers it with a three-state read cycle: it asserts that area's chip select, raises the read strobe, samples the data bus at the end of the last state, and returns the word together with the area number. A slow device can keep driving the bus for a while after its strobe drops. For that reason the sequencer can place one to four idle states in front of a read that immediately follows a read to a different area. During those idle states every select and the strobe stay low.

Three control inputs set the gap length. A global enable turns the feature on. There are two 2-bit gap fields, and each area has a select bit that picks which of the two fields applies when a read enters that area. All three controls are sampled when a request is accepted. Because of this, changing them while a cycle is in progress has no effect on that cycle.

Top module: `rd_gap_seq`

## Requirements
- R1: After synchronous reset the bus state code is 0 (free), all selects and the strobe are low, no response is valid and `req_ready` is high.
- R2: An accepted read runs the state codes 2 (T1), 3 (T2), 4 (T3) on consecutive cycles. The select bit of its area is the only one high in all three states. `bus_rd` is low in T1 and high in T2 and T3.
- R3: `req_ready` is high only while the state code is 0 (free) or 4 (T3). A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R4: Idle states are inserted only when the enable is 1 and the request is taken during T3 of a read to a different area. With the enable at 0, or with the same area, T1 follows T3 directly.
- R5: The gap field is chosen by the select bit of the area being entered, not the area being left. Bit value 0 selects `cfg_gap_a` and bit value 1 selects `cfg_gap_b`.
- R6: A gap field value v (0 to 3) inserts exactly v+1 idle states.
- R7: During idle states the state code is 1, every select is low and `bus_rd` is low.
- R8: `bus_data_in` is sampled at the end of T3. In the next cycle `rsp_valid` is high for exactly one cycle, with that word on `rsp_data` and the cycle's area on `rsp_area`.
- R9: A request taken while the bus is free (state 0) gets no idle states, whatever the previous read's area was.
- R10: The enable, select bits and gap fields are sampled only when the request is accepted. Changing them during the idle states leaves the gap length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_area | input | AREA_W | Target area of the request |
| cfg_idle_en | input | 1 | Enable for area-switch idle gaps |
| cfg_area_sel | input | N_AREA | Per-area choice between the two gap fields |
| cfg_gap_a | input | CNT_W | Gap field used when the select bit is 0 |
| cfg_gap_b | input | CNT_W | Gap field used when the select bit is 1 |
| bus_cs | output | N_AREA | Active-high chip select per area |
| bus_rd | output | 1 | Active-high read strobe |
| bus_state | output | 3 | State code: 0 free, 1 idle, 2 T1, 3 T2, 4 T3 |
| bus_data_in | input | DATA_W | Shared data bus |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_area | output | AREA_W | Area of the returned word |
| rsp_data | output | DATA_W | Returned read word |

## Verification
Two things happen on the same clock edge at the end of T3: the old cycle's data is captured, and the next request is accepted along with its gap decision. The bench provokes this by holding `req_valid` high through T3 with a new area. It then checks that both responses come back in order with data tied to the correct select, and that the count of idle-coded cycles between them matches the expected gap. A variant changes the enable and both gap fields during the idle states, and the bench checks that the gap length stays as it was. Another splits the two reads with a free cycle and expects no gap.

// File: rtl/rdg_pkg.sv
package rdg_pkg;
  typedef enum logic [2:0] {
    ST_FREE = 3'd0,
    ST_TI   = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_T3   = 3'd4
  } bus_st_e;
endpackage

// File: rtl/rdg_gap_calc.sv
module rdg_gap_calc #(
  parameter int N_AREA = 8,
  parameter int AREA_W = 3,
  parameter int CNT_W  = 2,
  parameter int GAP_W  = 3
) (
  input  logic              en,
  input  logic [N_AREA-1:0] area_sel,
  input  logic [CNT_W-1:0]  gap_a,
  input  logic [CNT_W-1:0]  gap_b,
  input  logic              prev_live,
  input  logic [AREA_W-1:0] prev_area,
  input  logic [AREA_W-1:0] new_area,
  output logic [GAP_W-1:0]  gap
);
  logic [CNT_W-1:0] field;
  logic             switch_hit;

  // the area being entered picks the field
  assign field      = area_sel[new_area] ? gap_b : gap_a;
  assign switch_hit = en && prev_live && (new_area != prev_area);

  always_comb begin
    gap = '0;
    if (switch_hit) gap = GAP_W'(field) + GAP_W'(1);
  end
endmodule

// File: rtl/rdg_fsm.sv
module rdg_fsm
  import rdg_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter int GAP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AREA_W-1:0] req_area,
  input  logic [GAP_W-1:0]  gap,
  output logic              req_ready,
  output logic              prev_live,
  output bus_st_e           st,
  output bus_st_e           st_nxt,
  output logic [AREA_W-1:0] cur_area,
  output logic [AREA_W-1:0] area_nxt
);
  logic [GAP_W-1:0] cnt, cnt_nxt;
  logic             take;

  assign req_ready = (st == ST_FREE) || (st == ST_T3);
  assign take      = req_valid && req_ready;
  assign prev_live = (st == ST_T3);

  always_comb begin
    st_nxt   = st;
    cnt_nxt  = cnt;
    area_nxt = cur_area;
    case (st)
      ST_TI: begin
        if (cnt == GAP_W'(1)) st_nxt = ST_T1;
        else                  cnt_nxt = cnt - GAP_W'(1);
      end
      ST_T1: st_nxt = ST_T2;
      ST_T2: st_nxt = ST_T3;
      ST_FREE, ST_T3: begin
        if (take) begin
          area_nxt = req_area;
          if (gap != '0) begin
            st_nxt  = ST_TI;
            cnt_nxt = gap;
          end else begin
            st_nxt = ST_T1;
          end
        end else if (st == ST_T3) begin
          st_nxt = ST_FREE;
        end
      end
      default: st_nxt = ST_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_FREE;
      cnt      <= '0;
      cur_area <= '0;
    end else begin
      st       <= st_nxt;
      cnt      <= cnt_nxt;
      cur_area <= area_nxt;
    end
  end

  // R2
  t1_to_t2_chk: assert property (@(posedge clk) disable iff (rst)
    st == ST_T1 |=> st == ST_T2);
  // R2
  t2_to_t3_chk: assert property (@(posedge clk) disable iff (rst)
    st == ST_T2 |=> st == ST_T3);
  // R9
  free_no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FREE && req_valid) |=> st == ST_T1);
  // R4
  same_area_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T3 && req_valid && req_area == cur_area) |=> st == ST_T1);
  // R3
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TI || st == ST_T1 || st == ST_T2) |-> !req_ready);
endmodule

// File: rtl/rdg_outreg.sv
module rdg_outreg
  import rdg_pkg::*;
#(
  parameter int N_AREA = 8,
  parameter int AREA_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_st_e           st,
  input  bus_st_e           st_nxt,
  input  logic [AREA_W-1:0] cur_area,
  input  logic [AREA_W-1:0] area_nxt,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic [N_AREA-1:0] bus_cs,
  output logic              bus_rd,
  output logic [2:0]        bus_state,
  output logic              rsp_valid,
  output logic [AREA_W-1:0] rsp_area,
  output logic [DATA_W-1:0] rsp_data
);
  logic in_cycle;
  assign in_cycle = (st_nxt == ST_T1) || (st_nxt == ST_T2) || (st_nxt == ST_T3);

  for (genvar gi = 0; gi < N_AREA; gi++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) bus_cs[gi] <= 1'b0;
      else     bus_cs[gi] <= in_cycle && (area_nxt == AREA_W'(gi));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd    <= 1'b0;
      bus_state <= 3'(ST_FREE);
      rsp_valid <= 1'b0;
      rsp_area  <= '0;
      rsp_data  <= '0;
    end else begin
      bus_rd    <= (st_nxt == ST_T2) || (st_nxt == ST_T3);
      bus_state <= 3'(st_nxt);
      rsp_valid <= (st == ST_T3);
      if (st == ST_T3) begin
        rsp_area <= cur_area;
        rsp_data <= bus_data_in;
      end
    end
  end

  // R7
  ti_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'(ST_TI) |-> (bus_cs == '0 && !bus_rd));
  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_cs));
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/rd_gap_seq.sv
module rd_gap_seq
  import rdg_pkg::*;
#(
  parameter int N_AREA = 8,
  parameter int CNT_W  = 2,
  parameter int DATA_W = 16,
  localparam int AREA_W = $clog2(N_AREA)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AREA_W-1:0] req_area,
  input  logic              cfg_idle_en,
  input  logic [N_AREA-1:0] cfg_area_sel,
  input  logic [CNT_W-1:0]  cfg_gap_a,
  input  logic [CNT_W-1:0]  cfg_gap_b,
  output logic [N_AREA-1:0] bus_cs,
  output logic              bus_rd,
  output logic [2:0]        bus_state,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic              rsp_valid,
  output logic [AREA_W-1:0] rsp_area,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int GAP_W = CNT_W + 1;

  logic [GAP_W-1:0]  gap;
  logic              prev_live;
  bus_st_e           st, st_nxt;
  logic [AREA_W-1:0] cur_area, area_nxt;

  rdg_gap_calc #(.N_AREA(N_AREA), .AREA_W(AREA_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_gap (
    .en(cfg_idle_en), .area_sel(cfg_area_sel), .gap_a(cfg_gap_a), .gap_b(cfg_gap_b),
    .prev_live(prev_live), .prev_area(cur_area), .new_area(req_area), .gap(gap)
  );

  rdg_fsm #(.AREA_W(AREA_W), .GAP_W(GAP_W)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_area(req_area), .gap(gap),
    .req_ready(req_ready), .prev_live(prev_live), .st(st), .st_nxt(st_nxt),
    .cur_area(cur_area), .area_nxt(area_nxt)
  );

  rdg_outreg #(.N_AREA(N_AREA), .AREA_W(AREA_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .st(st), .st_nxt(st_nxt), .cur_area(cur_area),
    .area_nxt(area_nxt), .bus_data_in(bus_data_in), .bus_cs(bus_cs), .bus_rd(bus_rd),
    .bus_state(bus_state), .rsp_valid(rsp_valid), .rsp_area(rsp_area), .rsp_data(rsp_data)
  );
endmodule

// File: tb/tb_rd_gap_seq.sv
`timescale 1ns/1ps
module tb_rd_gap_seq;
  localparam int N_AREA = 8;
  localparam int CNT_W  = 2;
  localparam int DATA_W = 16;
  localparam int AREA_W = 3;
  localparam logic [2:0] S_FREE = 3'd0, S_TI = 3'd1, S_T1 = 3'd2, S_T2 = 3'd3, S_T3 = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AREA_W-1:0] req_area = '0;
  logic cfg_idle_en = 1'b0;
  logic [N_AREA-1:0] cfg_area_sel = '0;
  logic [CNT_W-1:0] cfg_gap_a = '0, cfg_gap_b = '0;
  logic [N_AREA-1:0] bus_cs;
  logic bus_rd;
  logic [2:0] bus_state;
  logic [DATA_W-1:0] bus_data_in;
  logic rsp_valid;
  logic [AREA_W-1:0] rsp_area;
  logic [DATA_W-1:0] rsp_data;

  int total = 0, bad = 0;
  int rsp_n, ti_n;
  logic [AREA_W-1:0] rsp_q [2];
  logic [2:0] prev_st;
  logic prev_rsp;
  bit done = 0;

  always #2.5 clk = ~clk;

  rd_gap_seq #(.N_AREA(N_AREA), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut (.*);

  // each device drives a word derived from its area while selected
  always_comb begin
    bus_data_in = '0;
    for (int i = 0; i < N_AREA; i++)
      if (bus_cs[i]) bus_data_in = 16'hA000 + 16'(i);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe();
    chk(req_ready == (bus_state == S_FREE || bus_state == S_T3), "R3 ready", req_ready, 1);
    if (bus_state == S_TI) begin
      ti_n++;
      chk(bus_cs == '0 && !bus_rd, "R7 idle quiet", int'(bus_cs), 0);
    end
    if (bus_state == S_T1 || bus_state == S_T2 || bus_state == S_T3)
      chk($countones(bus_cs) == 1 && bus_rd == (bus_state != S_T1), "R2 pins",
          int'({bus_rd, bus_cs}), 1);
    if (prev_st == S_T1) chk(bus_state == S_T2, "R2 order", bus_state, S_T2);
    if (prev_st == S_T2) chk(bus_state == S_T3, "R2 order", bus_state, S_T3);
    if (rsp_valid) begin
      chk(!prev_rsp, "R8 pulse", 2, 1);
      chk(rsp_data == 16'hA000 + 16'(rsp_area), "R8 data", rsp_data, 16'hA000 + 16'(rsp_area));
      if (rsp_n < 2) rsp_q[rsp_n] = rsp_area;
      rsp_n++;
    end
    prev_st  = bus_state;
    prev_rsp = rsp_valid;
  endtask

  // two requests offered back to back; caller is at a negedge
  task automatic run_pair(input int a1, input int a2, input int exp_gap,
                          input string req, input bit mess);
    int acc = 0;
    bit pend = 0;
    rsp_n = 0; ti_n = 0; prev_st = S_FREE; prev_rsp = 0;
    req_valid = 1; req_area = AREA_W'(a1);
    for (int g = 0; g < 40 && rsp_n < 2; g++) begin
      if (req_valid && req_ready) begin acc++; pend = 1; end
      @(negedge clk);
      if (pend) begin
        pend = 0;
        if (acc == 1) req_area = AREA_W'(a2);
        else req_valid = 0;
      end
      observe();
      if (mess && bus_state == S_TI) begin
        cfg_idle_en = 0; cfg_gap_a = 0; cfg_gap_b = 0; cfg_area_sel = '1;
      end
    end
    chk(rsp_n == 2, {req, " responses"}, rsp_n, 2);
    chk(rsp_q[0] == AREA_W'(a1) && rsp_q[1] == AREA_W'(a2), {req, " R8 areas"},
        int'({rsp_q[0], rsp_q[1]}), int'({AREA_W'(a1), AREA_W'(a2)}));
    chk(ti_n == exp_gap, {req, " gap"}, ti_n, exp_gap);
    @(negedge clk);
    chk(bus_state == S_FREE, {req, " free"}, bus_state, S_FREE);
  endtask

  task automatic one_req(input int a);
    bit pend = 0;
    rsp_n = 0; prev_st = S_FREE; prev_rsp = 0;
    req_valid = 1; req_area = AREA_W'(a);
    for (int g = 0; g < 20 && rsp_n < 1; g++) begin
      if (req_valid && req_ready) pend = 1;
      @(negedge clk);
      if (pend) begin pend = 0; req_valid = 0; end
      observe();
    end
    chk(rsp_n == 1 && rsp_q[0] == AREA_W'(a), "R8 single", rsp_q[0], a);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_state == S_FREE, "R1 state", bus_state, S_FREE);
    chk(bus_cs == '0 && !bus_rd, "R1 pins", int'({bus_rd, bus_cs}), 0);
    chk(!rsp_valid, "R1 rsp", rsp_valid, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_split();
    cfg_idle_en = 1; cfg_area_sel = '0; cfg_gap_a = 2'd3;
    one_req(2);
    repeat (3) begin
      @(negedge clk);
      chk(bus_state == S_FREE, "R9 bus free", bus_state, S_FREE);
    end
    ti_n = 0;
    one_req(6);
    chk(ti_n == 0, "R9 no gap from free", ti_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    cfg_idle_en = 0; cfg_gap_a = 2'd3;
    run_pair(1, 5, 0, "R4 disabled", 0);
    cfg_idle_en = 1;
    run_pair(3, 3, 0, "R4 same area", 0);
    cfg_area_sel = '0; cfg_gap_a = 2'd0;
    run_pair(0, 6, 1, "R6 code0", 0);
    cfg_gap_a = 2'd3;
    run_pair(2, 7, 4, "R6 code3", 0);
    cfg_area_sel = 8'b0001_0000; cfg_gap_b = 2'd1;
    run_pair(0, 4, 2, "R5 field b", 0);
    cfg_area_sel = 8'b0010_0000; cfg_gap_a = 2'd2; cfg_gap_b = 2'd0;
    run_pair(5, 1, 3, "R5 entered area", 0);
    cfg_idle_en = 1; cfg_area_sel = '0; cfg_gap_a = 2'd3; cfg_gap_b = 2'd0;
    run_pair(6, 2, 4, "R10 sampled", 1);
    t_split();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule